// File: doc/BRIEF.md
# Memory Read/Write Address Sequencer

This block drives the address bus of a single-port external memory that holds plaintext words for an in-place encryption datapath. It alternates between two phases. In a read phase it places the read pointer on the bus and raises a read strobe. In the following write phase it places the write pointer on the bus and raises a write strobe. Each pointer advances by one only after its own phase. A single bus therefore carries one read and one write for every two enabled clocks.

The write pointer starts at a wrapped negative offset, which is minus the datapath latency measured in write slots (0x3FFF9 by default). The first few results land at the top of the address space. From then on, each ciphertext word is written back onto the location its plaintext came from. When the enable input is low, the sequencer freezes and both strobes drop.

Top module: `mem_addr_seq`

## Requirements
- R1: After a synchronous reset, the first enabled cycle is a read phase at address 0x00000. The following write phase presents address 0x3FFF9, which is 2^18 minus the lag of 7.
- R2: Both pointers are 18 bits wide and wrap modulo 2^18. The write pointer steps 0x3FFFF to 0x00000.
- R3: With enable held high, read phases and write phases strictly alternate, one of each per two clocks.
- R4: The read strobe (rd_stb_o) and the write strobe (wr_stb_o) are never high in the same cycle. rd_stb_o is high only in enabled read phases, and wr_stb_o only in enabled write phases.
- R5: The read pointer increments by one after each enabled read phase and is otherwise unchanged.
- R6: The write pointer increments by one after each enabled write phase and is otherwise unchanged.
- R7: The address of the n-th write (counting from 0 after reset) equals the address of read n-7, for n >= 7.
- R8: While en is low, the phase, both pointers and addr_o hold their values, and both strobes are low.
- R9: Asserting reset in the middle of a run returns the block to the state described in R1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the sequencer |
| addr_o | output | 18 | Shared memory address (read or write pointer) |
| rd_stb_o | output | 1 | Read strobe, high in enabled read phases |
| wr_stb_o | output | 1 | Write strobe, high in enabled write phases |

## Verification
The embedded assertions check the following on every cycle:
- the two strobes are exclusive;
- the phase toggles and each strobe is followed by its opposite;
- each pointer steps by exactly one per increment;
- everything freezes while enable is low;
- in every write phase, the write pointer trails the read pointer by the lag plus one.

Only the bench scenarios can show the absolute reset values, the wrap of the write pointer through the top of memory, and the resulting in-place property, where the address of each write matches the address of the read issued seven writes earlier. Recovery from a reset in mid-run also depends on the bench scenarios.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;

    localparam int SEQ_ADDR_W = 18;
    localparam int SEQ_LAG    = 7;

    typedef enum logic {
        PH_RD = 1'b0,
        PH_WR = 1'b1
    } phase_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    // Start value of the write pointer: minus the lag, wrapped to aw bits.
    function automatic int unsigned wrap_base(input int aw, input int lag);
        int unsigned span;
        span = 32'd1 << aw;
        return (span - int'(lag)) & (span - 1);
    endfunction

endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
    parameter int          W     = 18,
    parameter int unsigned START = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] START_V = W'(START);
    localparam logic [W-1:0] ONE     = W'(1);

    always_ff @(posedge clk) begin
        if (rst)      cnt_o <= START_V;
        else if (inc) cnt_o <= cnt_o + ONE;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        inc |=> cnt_o == $past(cnt_o) + ONE);   // R5, R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt_o));   // R5, R6
endmodule

// File: rtl/seq_phase.sv
module seq_phase
    import addr_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    output phase_e phase_o
);
    always_ff @(posedge clk) begin
        if (rst)     phase_o <= PH_RD;
        else if (en) phase_o <= (phase_o == PH_RD) ? PH_WR : PH_RD;
    end

    AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        en |=> phase_o != $past(phase_o));   // R3
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(phase_o));   // R8
endmodule

// File: rtl/seq_mux.sv
module seq_mux
    import addr_seq_pkg::*;
#(
    parameter int W = 18
) (
    input  phase_e       phase,
    input  logic         en,
    input  logic [W-1:0] rd_addr,
    input  logic [W-1:0] wr_addr,
    output logic [W-1:0] addr_o,
    output strobe_t      stb_o
);
    always_comb begin
        addr_o   = (phase == PH_WR) ? wr_addr : rd_addr;
        stb_o.rd = en && (phase == PH_RD);
        stb_o.wr = en && (phase == PH_WR);
    end
endmodule

// File: rtl/mem_addr_seq.sv
module mem_addr_seq
    import addr_seq_pkg::*;
#(
    parameter int ADDR_W = SEQ_ADDR_W,
    parameter int LAG    = SEQ_LAG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rd_stb_o,
    output logic              wr_stb_o
);
    localparam int unsigned    WR_START = wrap_base(ADDR_W, LAG);
    localparam logic [ADDR_W-1:0] GAP   = ADDR_W'(LAG + 1);

    phase_e            phase;
    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] wr_ptr;
    strobe_t           stb;

    seq_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .phase_o (phase)
    );

    seq_counter #(.W(ADDR_W), .START(0)) u_rd_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (stb.rd),
        .cnt_o (rd_ptr)
    );

    seq_counter #(.W(ADDR_W), .START(WR_START)) u_wr_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (stb.wr),
        .cnt_o (wr_ptr)
    );

    seq_mux #(.W(ADDR_W)) u_mux (
        .phase   (phase),
        .en      (en),
        .rd_addr (rd_ptr),
        .wr_addr (wr_ptr),
        .addr_o  (addr_o),
        .stb_o   (stb)
    );

    assign rd_stb_o = stb.rd;
    assign wr_stb_o = stb.wr;

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb_o && wr_stb_o));   // R4
    AST_RD_THEN_NOT_RD: assert property (@(posedge clk) disable iff (rst)
        rd_stb_o |=> !rd_stb_o);   // R3
    AST_WR_THEN_NOT_WR: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o);   // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!rd_stb_o && !wr_stb_o));   // R8
    AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(addr_o));   // R8
    AST_WR_TRAILS: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> (wr_ptr == rd_ptr - GAP));   // R7
endmodule

// File: tb/tb_mem_addr_seq.sv
module tb_mem_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 18;
    localparam int LAG = 7;
    localparam logic [AW-1:0] WR0 = 18'h3FFF9;

    logic          clk = 1'b0;
    logic          rst = 1'b0;
    logic          en  = 1'b0;
    logic [AW-1:0] addr_o;
    logic          rd_stb_o;
    logic          wr_stb_o;

    mem_addr_seq dut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .addr_o   (addr_o),
        .rd_stb_o (rd_stb_o),
        .wr_stb_o (wr_stb_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic          rd;
        logic          wr;
        logic [AW-1:0] addr;
        string         tag;
    } exp_t;

    exp_t          q[$];
    logic [AW-1:0] rd_seen[$];
    int            wr_idx = 0;
    int            n_checks = 0;
    int            n_fail = 0;
    bit            finished = 1'b0;

    // independent model of the requirements
    logic          m_ph;
    logic [AW-1:0] m_rd;
    logic [AW-1:0] m_wr;

    task automatic model_reset();
        m_ph = 1'b0;
        m_rd = '0;
        m_wr = WR0;
    endtask

    // called at a falling edge; drives one cycle
    task automatic drive(input logic v, input string tag);
        exp_t e;
        en     = v;
        e.rd   = v && !m_ph;
        e.wr   = v && m_ph;
        e.addr = m_ph ? m_wr : m_rd;
        e.tag  = tag;
        q.push_back(e);
        if (v) begin
            if (m_ph) m_wr = m_wr + 1'b1;
            else      m_rd = m_rd + 1'b1;
            m_ph = ~m_ph;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en  = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // monitor: scoreboard compare plus in-place (R7) check
    always @(negedge clk) begin
        #2;
        if (rst) begin
            rd_seen.delete();
            wr_idx = 0;
        end else if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (rd_stb_o !== e.rd || wr_stb_o !== e.wr || addr_o !== e.addr) begin
                n_fail++;
                $display("FAIL %s: got rd=%b wr=%b addr=%h, expected rd=%b wr=%b addr=%h",
                         e.tag, rd_stb_o, wr_stb_o, addr_o, e.rd, e.wr, e.addr);
            end
            if (rd_stb_o) rd_seen.push_back(addr_o);
            if (wr_stb_o) begin
                if (wr_idx >= LAG && wr_idx - LAG < rd_seen.size()) begin
                    n_checks++;
                    if (addr_o !== rd_seen[wr_idx - LAG]) begin
                        n_fail++;
                        $display("FAIL R7: write %0d addr=%h, expected %h",
                                 wr_idx, addr_o, rd_seen[wr_idx - LAG]);
                    end
                end
                wr_idx++;
            end
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset values
        drive(1'b1, "R1");
        drive(1'b1, "R1");
        // R3, R5, R6, R7: continuous run; R2: write pointer wraps at write 7
        for (int i = 0; i < 20; i++) drive(1'b1, "R3");
        for (int i = 0; i < 40; i++) drive(1'b1, "R2");
        // R8: enable gaps in several patterns, including one in a write phase
        drive(1'b0, "R8");
        drive(1'b0, "R8");
        drive(1'b1, "R8");
        drive(1'b0, "R8");
        drive(1'b1, "R8");
        for (int i = 0; i < 12; i++) drive(i % 3 != 0, "R8");
        for (int i = 0; i < 10; i++) drive(1'b1, "R5");
        // R9: reset in mid-run (currently in some phase with advanced pointers)
        drive(1'b1, "R6");
        do_reset();
        drive(1'b1, "R9");
        drive(1'b1, "R9");
        for (int i = 0; i < 30; i++) drive(1'b1, "R4");
        drive(1'b0, "R4");
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule